// File: doc/BRIEF.md
# Receive Character Queue with Interrupt Level

This block buffers received characters between a serial deserializer and the host. Every stored entry keeps the received byte together with three condition flags: parity error, overrun and end of frame. The oldest entry's byte and flags are always visible at the output. The host can therefore inspect a character's flags before it removes that character. The block also reports the fill count and whether any character is waiting.

Two interrupt requests are derived from the queue state. The first is the character-ready request. It fires when the fill count reaches a programmable level of either one character or half the queue. The second is the early condition request. It fires as soon as a flagged character sits within the near window, which is the first positions the host will read. It does not wait for the fill level to be reached.

The level select lives in a shadow configuration register. A write reaches the shadow register only while the shadow-access input is high. Otherwise the same write loads the interrupt mode register.

Top module: `rxq_irq_fifo`

## Requirements
- R1: After reset the fill count is 0, char_avail is 0, both interrupt requests are 0, the level select is 0 and the interrupt mode is disabled.
- R2: Entries leave in the order they were stored. While the queue is not empty, head_data and head_stat show the oldest entry's byte and flags. head_stat uses bit 0 for parity error, bit 1 for overrun and bit 2 for end of frame.
- R3: fill_cnt equals the number of stored entries and never exceeds DEPTH. char_avail is 1 exactly when fill_cnt is nonzero. A pop while the queue is empty has no effect.
- R4: A push into a full queue with no pop in the same cycle discards the incoming byte. fill_cnt stays at DEPTH, and bit 1 (overrun) is set in the flags of the most recently stored entry.
- R5: A push and a pop in the same cycle on a non-empty queue are both accepted and leave fill_cnt unchanged, including when the queue is full. On an empty queue only the push takes effect.
- R6: A cfg_we pulse with cfg_shadow_en=1 loads the level select from cfg_wdata bit 0 and leaves the mode unchanged. A pulse with cfg_shadow_en=0 loads the mode from cfg_wdata bits 1:0 and leaves the level select unchanged.
- R7: The mode encoding is 00 = interrupts disabled, 01 = all characters plus special conditions, 10 = special conditions only, and 11 = treated as disabled.
- R8: In mode 01, irq_rx is 1 exactly when fill_cnt is at least the selected level. The level is 1 when the level select is 0, and DEPTH/2 when it is 1. irq_rx falls in the same cycle that fill_cnt drops below the level. In any other mode irq_rx is 0.
- R9: In modes 01 and 10, irq_spec is 1 exactly when one of the first W stored entries, counted from the head, has any flag bit set. W is 1 when the level select is 0 and DEPTH/2 when it is 1. irq_spec stays high until that entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Store a received character |
| push_data | input | DW | Received byte |
| push_stat | input | 3 | Flags for the pushed byte: bit 0 parity, bit 1 overrun, bit 2 end of frame |
| pop | input | 1 | Host removes the head entry |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_shadow_en | input | 1 | Routes configuration writes to the level-select shadow register |
| cfg_wdata | input | 8 | Configuration write data |
| head_data | output | DW | Byte of the oldest entry |
| head_stat | output | 3 | Flags of the oldest entry |
| fill_cnt | output | $clog2(DEPTH+1) | Number of stored entries |
| char_avail | output | 1 | At least one entry is stored |
| irq_rx | output | 1 | Character-ready interrupt request |
| irq_spec | output | 1 | Early special-condition interrupt request |

## Verification
The bench aims at the full-queue edges. A design that dropped the pop during a simultaneous push and pop at full would lose count. A design that stored the overflowing byte would corrupt the head, and one that marked overrun on the wrong slot would show clean flags where bit 1 belongs. It moves the level select back and forth while the queue holds between one and four entries. In that range an off-by-one threshold, or a window that ignores the select, shows up as a wrongly timed irq_rx or irq_spec. It also writes the shared configuration address with the shadow-access input both high and low, so that a write leaking into the wrong register changes interrupt behaviour at once.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int FLAG_W  = 3;
  localparam int THR_BIT = 0;

  typedef struct packed {
    logic eof;
    logic ovr;
    logic par;
  } rx_flag_t;

  typedef enum logic [1:0] {
    IRQ_OFF  = 2'b00,
    IRQ_ALL  = 2'b01,
    IRQ_SPEC = 2'b10,
    IRQ_RSVD = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/rxq_cfg.sv
module rxq_cfg
  import rxq_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             shadow_en,
  input  logic [CFG_W-1:0] wdata,
  output logic             thr_sel,
  output irq_mode_e        mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_sel <= 1'b0;
      mode    <= IRQ_OFF;
    end else if (cfg_we) begin
      if (shadow_en) thr_sel <= wdata[THR_BIT];
      else           mode    <= irq_mode_e'(wdata[1:0]);
    end
  end

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && shadow_en) |=> $stable(mode));
  // R6
  main_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !shadow_en) |=> $stable(thr_sel));
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int WIN   = DEPTH / 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [DW-1:0]  push_data,
  input  rx_flag_t       push_flag,
  input  logic           pop,
  output logic [DW-1:0]  head_data,
  output rx_flag_t       head_flag,
  output logic [CW-1:0]  cnt,
  output logic [WIN-1:0] near_flag
);
  // DEPTH is expected to be a power of two so pointers wrap naturally.
  logic [DW-1:0] mem [DEPTH];
  rx_flag_t      flg [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr, tail;
  logic [CW-1:0] cnt_q;
  logic          empty, full, do_pop, do_push, ovf;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign ovf     = push & full & ~do_pop;
  assign tail    = wr_ptr - AW'(1);

  // byte storage: no reset, single write port, async read (distributed RAM)
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) flg[i] <= '0;
    end else begin
      if (do_push) flg[wr_ptr] <= push_flag;
      if (ovf)     flg[tail].ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign head_data = mem[rd_ptr];
  assign head_flag = flg[rd_ptr];
  assign cnt       = cnt_q;

  for (genvar k = 0; k < WIN; k++) begin : g_near
    assign near_flag[k] = (CW'(k) < cnt_q) && (|flg[rd_ptr + AW'(k)]);
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (cnt_q == '0));
  // R5
  both_ops_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty) |=> $stable(cnt_q));
  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
  import rxq_pkg::*;
#(
  parameter int WIN = 4,
  parameter int CW  = 4
) (
  input  logic           thr_sel,
  input  irq_mode_e      mode,
  input  logic [CW-1:0]  cnt,
  input  logic [WIN-1:0] near_flag,
  output logic           irq_rx,
  output logic           irq_spec
);
  logic [CW-1:0]  lvl;
  logic [WIN-1:0] mask;

  assign lvl = thr_sel ? CW'(WIN) : CW'(1);

  for (genvar k = 0; k < WIN; k++) begin : g_mask
    if (k == 0) begin : g_first
      assign mask[k] = 1'b1;
    end else begin : g_rest
      assign mask[k] = thr_sel;
    end
  end

  assign irq_rx   = (mode == IRQ_ALL) && (cnt >= lvl);
  assign irq_spec = ((mode == IRQ_ALL) || (mode == IRQ_SPEC)) && |(near_flag & mask);
endmodule

// File: rtl/rxq_irq_fifo.sv
module rxq_irq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DW     = 8,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int WIN   = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [2:0]    push_stat,
  input  logic          pop,
  input  logic          cfg_we,
  input  logic          cfg_shadow_en,
  input  logic [7:0]    cfg_wdata,
  output logic [DW-1:0] head_data,
  output logic [2:0]    head_stat,
  output logic [CW-1:0] fill_cnt,
  output logic          char_avail,
  output logic          irq_rx,
  output logic          irq_spec
);
  logic           thr_sel;
  irq_mode_e      mode;
  rx_flag_t       hflag;
  logic [WIN-1:0] near_flag;

  rxq_cfg #(.CFG_W(8)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .shadow_en(cfg_shadow_en),
    .wdata(cfg_wdata), .thr_sel(thr_sel), .mode(mode)
  );

  rxq_store #(.DEPTH(DEPTH), .DW(DW), .WIN(WIN)) u_store (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .push_flag(rx_flag_t'(push_stat)), .pop(pop),
    .head_data(head_data), .head_flag(hflag), .cnt(fill_cnt),
    .near_flag(near_flag)
  );

  rxq_irq #(.WIN(WIN), .CW(CW)) u_irq (
    .thr_sel(thr_sel), .mode(mode), .cnt(fill_cnt), .near_flag(near_flag),
    .irq_rx(irq_rx), .irq_spec(irq_spec)
  );

  assign head_stat  = hflag;
  assign char_avail = (fill_cnt != '0);

  // R8
  rx_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    irq_rx |-> char_avail);
  // R9
  spec_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    irq_spec |-> char_avail);
endmodule

// File: tb/rxq_irq_fifo_tb.sv
`timescale 1ns/1ps
module rxq_irq_fifo_tb;
  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int HALF  = DEPTH / 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, push, pop, cfg_we, cfg_shadow_en;
  logic [DW-1:0] push_data, head_data;
  logic [2:0] push_stat, head_stat;
  logic [7:0] cfg_wdata;
  logic [CW-1:0] fill_cnt;
  logic char_avail, irq_rx, irq_spec;

  rxq_irq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .push_stat(push_stat), .pop(pop), .cfg_we(cfg_we),
    .cfg_shadow_en(cfg_shadow_en), .cfg_wdata(cfg_wdata),
    .head_data(head_data), .head_stat(head_stat), .fill_cnt(fill_cnt),
    .char_avail(char_avail), .irq_rx(irq_rx), .irq_spec(irq_spec)
  );

  typedef struct { logic [DW-1:0] d; logic [2:0] s; } ent_t;
  ent_t q[$];
  logic [1:0] m_mode;
  logic       m_thr;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int lvl = m_thr ? HALF : 1;
    int exp_spec = 0;
    int exp_rx;
    exp_rx = (m_mode == 2'b01 && q.size() >= lvl) ? 1 : 0;
    if (m_mode == 2'b01 || m_mode == 2'b10)
      for (int k = 0; k < q.size() && k < lvl; k++)
        if (q[k].s != 3'b000) exp_spec = 1;
    chk("R3 R4 R5 fill_cnt", int'(fill_cnt), q.size());
    chk("R3 char_avail", int'(char_avail), (q.size() != 0) ? 1 : 0);
    if (q.size() > 0) begin
      chk("R2 head_data", int'(head_data), int'(q[0].d));
      chk("R2 R4 head_stat", int'(head_stat), int'(q[0].s));
    end
    chk("R6 R7 R8 irq_rx", int'(irq_rx), exp_rx);
    chk("R6 R7 R9 irq_spec", int'(irq_spec), exp_spec);
  endtask

  task automatic step(int push_p, int pop_p, int cfg_p);
    bit full, dpop;
    @(negedge clk);
    compare_all();
    push      = (($urandom % 100) < push_p);
    pop       = (($urandom % 100) < pop_p);
    push_data = DW'($urandom);
    push_stat = (($urandom % 100) < 15) ? 3'($urandom) : 3'b000;
    cfg_we    = (($urandom % 100) < cfg_p);
    cfg_shadow_en = $urandom % 2;
    cfg_wdata = 8'($urandom);
    @(posedge clk);
    full = (q.size() == DEPTH);
    dpop = pop && (q.size() > 0);
    if (push && full && !dpop) q[q.size()-1].s[1] = 1'b1;
    else begin
      if (dpop) void'(q.pop_front());
      if (push) q.push_back('{d: push_data, s: push_stat});
    end
    if (cfg_we) begin
      if (cfg_shadow_en) m_thr = cfg_wdata[0];
      else m_mode = cfg_wdata[1:0];
    end
  endtask

  initial begin
    rst = 1'b1; push = 0; pop = 0; cfg_we = 0; cfg_shadow_en = 0;
    push_data = '0; push_stat = '0; cfg_wdata = '0;
    m_mode = 2'b00; m_thr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 fill_cnt", int'(fill_cnt), 0);
    chk("R1 char_avail", int'(char_avail), 0);
    chk("R1 irq_rx", int'(irq_rx), 0);
    chk("R1 irq_spec", int'(irq_spec), 0);
    // reset mode disabled: fill a few, no interrupts expected (R1 R7)
    repeat (20) step(80, 0, 0);
    for (int ph = 0; ph < 6; ph++) begin
      for (int i = 0; i < 2000; i++) begin
        case (ph)
          0: step(60, 40, 4);
          1: step(90, 10, 4);   // pushes into full queue: R4
          2: step(95, 95, 3);   // simultaneous ops at full/empty: R5
          3: step(30, 30, 8);   // 1..4 entries with select toggling: R8 R9
          4: step(10, 90, 4);   // pops on empty: R3
          default: step(50, 50, 20); // frequent config writes: R6
        endcase
      end
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule